// File: doc/BRIEF.md
# Parallel Slave Port Interface

This block lets an external microprocessor read and write a byte-wide port of the chip through an asynchronous bus. The bus has an active-low chip select, an active-low read strobe, an active-low write strobe and a byte of data. The chip-side logic reaches the port through a synchronous register interface. Through it, the chip side sets the outgoing byte, fetches the incoming byte, reads the status flags and acknowledges the interrupt.

A mode input selects between two behaviours. When it is clear, the block is an ordinary port: each data pin is driven or left floating according to a direction register, and the synchronized pin levels can be read back. When it is set, the data pins form a slave bus. Each control input passes through a synchronizer. An access is counted once, at the first sampled cycle in which chip select and a strobe are both low.

Each detected access raises a shared interrupt flag. Buffer-full flags show whether the incoming byte is still unread and whether the outgoing byte has not yet been fetched. An overflow flag records an external write that arrived while the previous byte was still unread.

Top module: `psp_port`

## Requirements
- R1: After reset the direction register reads 0xFF, both data latches are 0, every status flag is 0, `irq_o` is 0 and `data_oe_o` is 0.
- R2: With `mode_en_i` low, `data_oe_o` equals the inverse of the direction register (1 = input), `data_o` carries the output latch, and bus strobes change no flag.
- R3: With `mode_en_i` high, an external write (chip select and write strobe low) captures the synchronized bus byte into the input latch and sets input-full (status bit 0). Reading register address 0 returns that byte and clears input-full.
- R4: A chip select and write strobe held low for many cycles count as one access, so no overflow (status bit 2) follows.
- R5: An external write while input-full is set and not being read sets overflow (status bit 2). The input latch then keeps the newest byte. Writing 1 to status bit 2 (address 2) clears overflow.
- R6: With `mode_en_i` high, `data_oe_o` is 0xFF exactly while chip select and read strobe are both low at the pins, and is 0x00 otherwise. `data_o` carries the output latch.
- R7: In slave mode, a write to address 0 loads the output latch and sets output-full (status bit 1). A detected external read clears output-full.
- R8: Each detected access sets the interrupt flag (`irq_o`, status bit 3). Writing 1 to status bit 3 clears it. An access in the same cycle as the clear wins, and the flag stays set.
- R9: A write strobe low while chip select is high is not an access: no flag changes.
- R10: Reading address 3 returns the data pins through the synchronizer. The direction register is at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_en_i | input | 1 | 1 = slave bus, 0 = plain port |
| ext_cs_ni | input | 1 | External chip select, active low, asynchronous |
| ext_rd_ni | input | 1 | External read strobe, active low, asynchronous |
| ext_wr_ni | input | 1 | External write strobe, active low, asynchronous |
| data_i | input | 8 | Data pin input levels |
| data_o | output | 8 | Data pin output values |
| data_oe_o | output | 8 | Data pin output enables, 1 = drive |
| reg_we_i | input | 1 | Internal register write |
| reg_re_i | input | 1 | Internal register read (side effects) |
| reg_addr_i | input | 2 | Register address: 0 data, 1 direction, 2 status, 3 pins |
| reg_wdata_i | input | 8 | Internal write data |
| reg_rdata_o | output | 8 | Internal read data, combinational |
| irq_o | output | 1 | Port interrupt flag |

## Verification
The assertions check on every cycle that an access detection lasts one cycle, and that it captures the synchronized byte and sets input-full. They also check that an unread byte followed by a write yields overflow, that an external read clears output-full, and that the interrupt flag survives a clear that coincides with an access. Only the bench scenarios can show the end-to-end latency from pin to status, the bus turn-on and turn-off at the pins, plain-port direction control, and that strobes without chip select or outside slave mode leave every flag untouched.

// File: rtl/psp_pkg.sv
package psp_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_PINS = 2'd3
  } psp_addr_e;

  localparam int unsigned ST_IBF = 0;
  localparam int unsigned ST_OBF = 1;
  localparam int unsigned ST_OVF = 2;
  localparam int unsigned ST_IRQ = 3;
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/psp_access_det.sv
module psp_access_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cs_n_i,
  input  logic strobe_n_i,
  output logic pulse_o
);
  logic act, act_q;

  assign act = ~cs_n_i & ~strobe_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  // first sampled low only
  assign pulse_o = en_i & act & ~act_q;

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/psp_flags.sv
module psp_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_pulse_i,
  input  logic rd_pulse_i,
  input  logic data_rd_i,
  input  logic data_wr_i,
  input  logic ovf_clr_i,
  input  logic irq_clr_i,
  output logic ibf_o,
  output logic obf_o,
  output logic ovf_o,
  output logic irq_o
);
  logic ibf_q, obf_q, ovf_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_pulse_i)     ibf_q <= 1'b1;
      else if (data_rd_i) ibf_q <= 1'b0;

      if (data_wr_i)       obf_q <= 1'b1;
      else if (rd_pulse_i) obf_q <= 1'b0;

      if (wr_pulse_i && ibf_q && !data_rd_i) ovf_q <= 1'b1;
      else if (ovf_clr_i)                    ovf_q <= 1'b0;

      // set beats clear
      if (wr_pulse_i || rd_pulse_i) irq_q <= 1'b1;
      else if (irq_clr_i)           irq_q <= 1'b0;
    end
  end

  assign ibf_o = ibf_q;
  assign obf_o = obf_q;
  assign ovf_o = ovf_q;
  assign irq_o = irq_q;

  assert_ibf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_i |=> ibf_o);
  assert_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse_i && ibf_o && !data_rd_i) |=> ovf_o);
  assert_obf_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pulse_i && !data_wr_i) |=> !obf_o);
  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse_i || rd_pulse_i) |=> irq_o);
endmodule

// File: rtl/psp_port.sv
module psp_port
  import psp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              ext_cs_ni,
  input  logic              ext_rd_ni,
  input  logic              ext_wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = 3;

  logic [DATA_W-1:0] out_q, in_q, dir_q, data_sync;
  logic [CTRL_W-1:0] ctrl_sync;
  logic cs_s, rd_s, wr_s;
  logic wr_pulse, rd_pulse;
  logic data_rd, data_wr, ovf_clr, irq_clr;
  logic ibf, obf, ovf, irq;
  psp_addr_e addr;

  assign addr = psp_addr_e'(reg_addr_i);

  psp_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_cs_ni, ext_rd_ni, ext_wr_ni}),
    .q_o   (ctrl_sync)
  );
  assign {cs_s, rd_s, wr_s} = ctrl_sync;

  psp_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (data_sync)
  );

  psp_access_det u_wr_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_en_i),
    .cs_n_i    (cs_s),
    .strobe_n_i(wr_s),
    .pulse_o   (wr_pulse)
  );

  psp_access_det u_rd_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_en_i),
    .cs_n_i    (cs_s),
    .strobe_n_i(rd_s),
    .pulse_o   (rd_pulse)
  );

  assign data_rd = reg_re_i && addr == ADDR_DATA;
  assign data_wr = reg_we_i && addr == ADDR_DATA && mode_en_i;
  assign ovf_clr = reg_we_i && addr == ADDR_STAT && reg_wdata_i[ST_OVF];
  assign irq_clr = reg_we_i && addr == ADDR_STAT && reg_wdata_i[ST_IRQ];

  psp_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_pulse_i(wr_pulse),
    .rd_pulse_i(rd_pulse),
    .data_rd_i (data_rd),
    .data_wr_i (data_wr),
    .ovf_clr_i (ovf_clr),
    .irq_clr_i (irq_clr),
    .ibf_o     (ibf),
    .obf_o     (obf),
    .ovf_o     (ovf),
    .irq_o     (irq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      in_q  <= '0;
      dir_q <= '1;
    end else begin
      if (reg_we_i && addr == ADDR_DATA) out_q <= reg_wdata_i;
      if (reg_we_i && addr == ADDR_DIR)  dir_q <= reg_wdata_i;
      if (wr_pulse)                      in_q  <= data_sync;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      ADDR_DATA: reg_rdata_o = in_q;
      ADDR_DIR:  reg_rdata_o = dir_q;
      ADDR_STAT: begin
        reg_rdata_o[ST_IBF] = ibf;
        reg_rdata_o[ST_OBF] = obf;
        reg_rdata_o[ST_OVF] = ovf;
        reg_rdata_o[ST_IRQ] = irq;
      end
      ADDR_PINS: reg_rdata_o = data_sync;
      default:   reg_rdata_o = '0;
    endcase
  end

  // bus driven straight from raw pins; no clock in the enable path
  assign data_oe_o = mode_en_i ? {DATA_W{~ext_cs_ni & ~ext_rd_ni}} : ~dir_q;
  assign data_o    = out_q;
  assign irq_o     = irq;

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |=> in_q == $past(data_sync));
  assert_no_access_plain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_en_i && !ibf) |=> !$rose(ibf));
endmodule

// File: tb/sim_psp_port.sv
module sim_psp_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_en = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, doe, rdata;
  logic       we = 1'b0, re = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  psp_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_en_i(mode_en),
    .ext_cs_ni(cs_n), .ext_rd_ni(rd_n), .ext_wr_ni(wr_n),
    .data_i(din), .data_o(dout), .data_oe_o(doe),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ext_wr(logic [7:0] b, int hold);
    @(negedge clk); din = b; cs_n = 1'b0; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe", doe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    peek(2'd2, v); chk("R1 status", v, 8'h00);
    peek(2'd1, v); chk("R1 dir", v, 8'hFF);
    peek(2'd0, v); chk("R1 in latch", v, 8'h00);
    chk("R1 out latch", dout, 8'h00);
  endtask

  task automatic t_plain;
    logic [7:0] v;
    reg_wr(2'd1, 8'h0F);
    reg_wr(2'd0, 8'hA5);
    @(negedge clk);
    chk("R2 oe", doe, 8'hF0);
    chk("R2 data_o", dout, 8'hA5);
    ext_wr(8'h66, 3);
    peek(2'd2, v); chk("R2 strobes ignored", v, 8'h00);
    chk("R2 irq", {7'd0, irq}, 8'h00);
    din = 8'h3C;
    repeat (3) @(negedge clk);
    peek(2'd3, v); chk("R10 pins", v, 8'h3C);
  endtask

  task automatic t_ext_write;
    logic [7:0] v;
    ext_wr(8'h5A, 2);
    peek(2'd2, v); chk("R3 ibf+irq", v, 8'h09);
    chk("R8 irq_o", {7'd0, irq}, 8'h01);
    reg_rd(2'd0, v); chk("R3 data", v, 8'h5A);
    peek(2'd2, v); chk("R3 ibf cleared", v, 8'h08);
    reg_wr(2'd2, 8'h08);
    peek(2'd2, v); chk("R8 irq cleared", v, 8'h00);
  endtask

  task automatic t_long;
    logic [7:0] v;
    ext_wr(8'h11, 20);
    peek(2'd2, v); chk("R4 one access", v, 8'h09);
    reg_rd(2'd0, v); chk("R4 data", v, 8'h11);
    reg_wr(2'd2, 8'h08);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    ext_wr(8'h22, 2);
    ext_wr(8'h33, 2);
    peek(2'd2, v); chk("R5 ovf", v, 8'h0D);
    reg_rd(2'd0, v); chk("R5 newest", v, 8'h33);
    reg_wr(2'd2, 8'h04);
    peek(2'd2, v); chk("R5 ovf cleared", v, 8'h08);
    reg_wr(2'd2, 8'h08);
  endtask

  task automatic t_no_cs;
    logic [7:0] v;
    @(negedge clk); din = 8'h77; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd2, v); chk("R9 no access", v, 8'h00);
  endtask

  task automatic t_ext_read;
    logic [7:0] v;
    reg_wr(2'd0, 8'h7E);
    peek(2'd2, v); chk("R7 obf set", v, 8'h02);
    chk("R6 idle float", doe, 8'h00);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    #1 chk("R6 drive", doe, 8'hFF);
    chk("R6 data", dout, 8'h7E);
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    #1 chk("R6 release", doe, 8'h00);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd2, v); chk("R7 obf cleared", v, 8'h08);
    reg_wr(2'd2, 8'h08);
  endtask

  task automatic t_irq_prio;
    logic [7:0] v;
    chk("R8 irq low before", {7'd0, irq}, 8'h00);
    @(negedge clk); din = 8'h44; cs_n = 1'b0; wr_n = 1'b0; // before edge k
    @(negedge clk);                                         // after k
    we = 1'b1; addr = 2'd2; wdata = 8'h08;                  // sampled at k+2
    @(negedge clk);
    @(negedge clk); we = 1'b0;
    chk("R8 access wins", {7'd0, irq}, 8'h01);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_wr(2'd2, 8'h08);
    chk("R8 cleared", {7'd0, irq}, 8'h00);
    reg_rd(2'd0, v); chk("R8 data", v, 8'h44);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    mode_en = 1'b1;
    repeat (2) @(negedge clk);
    t_ext_write();
    t_long();
    t_overflow();
    t_no_cs();
    t_ext_read();
    t_irq_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule